// File: doc/BRIEF.md
# Reference-to-Signal Edge Delay Meter

This block watches two single-bit inputs on a fast sampling clock. The first is a reference clock, and the second is a signal that responds to it. The block measures how many samples separate each active reference edge from the first active signal edge that follows it, and it reports that count together with a one-cycle valid pulse.

A two-state machine alternates between waiting for a reference edge and waiting for a signal edge. Edges that arrive while the machine waits for the other input are unpaired. The block keeps a saturating counter for unpaired reference edges and another for unpaired signal edges, and each counter has its own increment pulse. Each input has a configuration bit that selects whether its rising or its falling edges are the active ones.

The inputs are assumed to be already synchronous to the sampling clock. Software or a later stage turns the counts into time.

Top module: `cdm_delay_meter`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block does the following: it enters the wait-for-reference state, clears both miss counters, drives the delay output, the valid pulse and both increment pulses to zero, and marks the signal history as empty. The sample index restarts from 0.
- R2: An edge on an input is detected by comparing the input with its value on the previous sample. A polarity bit of 1 selects rising edges (0 then 1) and a polarity bit of 0 selects falling edges (1 then 0). Transitions in the other direction have no effect.
- R3: In the wait-for-reference state, a reference edge that does not coincide with a signal edge records the current sample index. The machine then moves to the wait-for-signal state and produces no delay output.
- R4: In the wait-for-signal state, a signal edge produces a delay equal to the current sample index minus the recorded reference index, modulo 2^IDX_W. The delay appears on `delay_o` with `delay_vld_o` high for exactly one cycle, registered one clock after the sample that held the edge.
- R5: In the wait-for-signal state, a reference edge with no signal edge on the same sample increments the missed-reference counter. It does not restart the measurement, so the next delay is still measured from the first reference edge.
- R6: In the wait-for-reference state, a lone signal edge increments the missed-signal counter only if at least one signal edge has been paired since reset. The first signal edge after reset is never counted.
- R7: If a reference edge and a signal edge fall on the same sample in the wait-for-reference state, the block reports a delay of 0, counts no miss, and stays in the wait-for-reference state.
- R8: If both edges fall on the same sample in the wait-for-signal state, the current measurement completes and is reported. That sample's reference edge then starts a new measurement, and no miss is counted.
- R9: Each miss counter holds at its all-ones maximum. Its increment pulse is high for exactly one cycle, registered, only when the count actually rises by one.
- R10: No two of `delay_vld_o`, `miss_ref_inc_o` and `miss_sig_inc_o` are ever high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_i | input | 1 | Reference clock sample |
| sig_i | input | 1 | Resulting signal sample |
| ref_rise_i | input | 1 | 1: rising reference edges are active, 0: falling |
| sig_rise_i | input | 1 | 1: rising signal edges are active, 0: falling |
| delay_o | output | IDX_W | Last measured delay in samples |
| delay_vld_o | output | 1 | One-cycle pulse when `delay_o` is new |
| miss_ref_cnt_o | output | MISS_W | Saturating count of unpaired reference edges |
| miss_ref_inc_o | output | 1 | Pulse when the missed-reference count rises |
| miss_sig_cnt_o | output | MISS_W | Saturating count of unpaired signal edges |
| miss_sig_inc_o | output | 1 | Pulse when the missed-signal count rises |

## Verification
Directed patterns cover the cases one at a time. A lone signal edge straight after reset separates the first-edge exemption from a real miss. Two reference edges before one signal edge separate "count a miss" from "restart the measurement". Coincident edges in each state separate the zero-delay pair from the chained re-arm, and a run with falling polarity shows that transitions in the other direction are ignored. Toggle bursts drive both counters into saturation, and a long random phase with polarity flips and mid-run resets is checked cycle by cycle against a behavioural model.

// File: rtl/cdm_pkg.sv
// Package: shared types for the edge delay meter.
// Assumes: nothing; holds only the pairing-machine state encoding.
package cdm_pkg;

    // Pairing machine: waiting for a reference edge, or for a signal edge.
    typedef enum logic {
        ST_WAIT_REF = 1'b0,
        ST_WAIT_SIG = 1'b1
    } cdm_state_e;

endpackage

// File: rtl/cdm_edge_det.sv
// Module: cdm_edge_det
// Detects an active edge on each lane by comparing the lane with its value
// on the previous sample. A per-lane polarity bit selects rising (1) or
// falling (0) edges.
// Assumes: the inputs are already synchronous to clk. The previous-sample
// register keeps tracking during reset, so the first sample after reset only
// shows a real change.
module cdm_edge_det #(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic [LANES-1:0] din_i,
    input  logic [LANES-1:0] rise_i,
    output logic [LANES-1:0] edge_o
);

    logic [LANES-1:0] prev_q;

    // Hold each lane's value from the previous sample.
    always_ff @(posedge clk) begin
        prev_q <= din_i;
    end

    // Per-lane edge qualification by the selected polarity.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign edge_o[g] = rise_i[g] ? (din_i[g] & ~prev_q[g])
                                     : (~din_i[g] & prev_q[g]);
    end

endmodule

// File: rtl/cdm_idx_ctr.sv
// Module: cdm_idx_ctr
// Free-running sample index. It is 0 on the first sample after reset and
// advances by one on every sample, wrapping modulo 2^W.
// Assumes: one sample per clk cycle.
module cdm_idx_ctr #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] idx_o
);

    // Count samples since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) idx_o <= '0;
        else        idx_o <= idx_o + 1'b1;
    end

endmodule

// File: rtl/cdm_sat_ctr.sv
// Module: cdm_sat_ctr
// Saturating event counter with a registered one-cycle increment pulse.
// The pulse is raised only when the count actually changes.
// Assumes: at most one increment request per cycle.
module cdm_sat_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o,
    output logic         pulse_o
);

    localparam logic [W-1:0] MAX = {W{1'b1}};

    logic at_max;
    assign at_max = (cnt_o == MAX);

    // Advance the count below saturation and flag each real step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o   <= '0;
            pulse_o <= 1'b0;
        end else begin
            pulse_o <= inc_i && !at_max;
            if (inc_i && !at_max) cnt_o <= cnt_o + 1'b1;
        end
    end

    // R9
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o == MAX) |=> (cnt_o == MAX));

    // R9
    inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> (cnt_o == $past(cnt_o) + 1'b1));

endmodule

// File: rtl/cdm_pair_fsm.sv
// Module: cdm_pair_fsm
// Two-state pairing machine. It pairs each reference edge with the next
// signal edge and computes the delay in samples. It also raises miss requests
// for unpaired edges. Each sample is evaluated once, with the same-sample
// combinations resolved as a sequential walk through the states would.
// Assumes: edges arrive as single-sample strobes aligned with idx_i.
module cdm_pair_fsm
    import cdm_pkg::*;
#(
    parameter int IDX_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_edge_i,
    input  logic             sig_edge_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [IDX_W-1:0] dly_o,
    output logic             dly_vld_o,
    output logic             miss_ref_req_o,
    output logic             miss_sig_req_o
);

    cdm_state_e       state_q, state_d;
    logic [IDX_W-1:0] ref_idx_q;
    logic             sig_seen_q;
    logic             pair;
    logic             take_ref;
    logic [IDX_W-1:0] dly_d;

    // Decide this sample's action from the state and the edge pair.
    always_comb begin
        state_d        = state_q;
        pair           = 1'b0;
        take_ref       = 1'b0;
        dly_d          = '0;
        miss_ref_req_o = 1'b0;
        miss_sig_req_o = 1'b0;
        unique case (state_q)
            ST_WAIT_REF: begin
                if (ref_edge_i && sig_edge_i) begin
                    pair     = 1'b1;
                    take_ref = 1'b1;
                end else if (ref_edge_i) begin
                    take_ref = 1'b1;
                    state_d  = ST_WAIT_SIG;
                end else if (sig_edge_i && sig_seen_q) begin
                    miss_sig_req_o = 1'b1;
                end
            end
            ST_WAIT_SIG: begin
                if (sig_edge_i) begin
                    pair  = 1'b1;
                    dly_d = idx_i - ref_idx_q;
                    if (ref_edge_i) take_ref = 1'b1;
                    else            state_d  = ST_WAIT_REF;
                end else if (ref_edge_i) begin
                    miss_ref_req_o = 1'b1;
                end
            end
            default: state_d = ST_WAIT_REF;
        endcase
    end

    // Update the state, the recorded reference index and the signal history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_WAIT_REF;
            ref_idx_q  <= '0;
            sig_seen_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (take_ref) ref_idx_q  <= idx_i;
            if (pair)     sig_seen_q <= 1'b1;
        end
    end

    // Register the delay result and its one-cycle valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_o     <= '0;
            dly_vld_o <= 1'b0;
        end else begin
            dly_vld_o <= pair;
            if (pair) dly_o <= dly_d;
        end
    end

    // R3
    ref_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_REF && ref_edge_i && !sig_edge_i)
            |=> (state_q == ST_WAIT_SIG && !dly_vld_o));

    // R7
    zero_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_REF && ref_edge_i && sig_edge_i)
            |=> (dly_vld_o && dly_o == '0 && state_q == ST_WAIT_REF));

    // R8
    chain_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_SIG && ref_edge_i && sig_edge_i)
            |=> (dly_vld_o && state_q == ST_WAIT_SIG));

    // R6
    first_sig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sig_seen_q && state_q == ST_WAIT_REF) |-> !miss_sig_req_o);

endmodule

// File: rtl/cdm_delay_meter.sv
// Module: cdm_delay_meter (top)
// Measures the delay in samples from each active reference edge to the next
// active signal edge. It counts unpaired edges of each input in saturating
// counters. All outputs are registered.
// Assumes: ref_i and sig_i are synchronous to clk. The polarity bits are
// sampled together with the data.
module cdm_delay_meter #(
    parameter int IDX_W  = 32,
    parameter int MISS_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_i,
    input  logic              sig_i,
    input  logic              ref_rise_i,
    input  logic              sig_rise_i,
    output logic [IDX_W-1:0]  delay_o,
    output logic              delay_vld_o,
    output logic [MISS_W-1:0] miss_ref_cnt_o,
    output logic              miss_ref_inc_o,
    output logic [MISS_W-1:0] miss_sig_cnt_o,
    output logic              miss_sig_inc_o
);

    localparam int LANES   = 2;
    localparam int LANE_RF = 0;
    localparam int LANE_SG = 1;

    logic [LANES-1:0] edges;
    logic [IDX_W-1:0] idx;
    logic             miss_ref_req;
    logic             miss_sig_req;

    cdm_edge_det #(.LANES(LANES)) u_edge (
        .clk    (clk),
        .din_i  ({sig_i, ref_i}),
        .rise_i ({sig_rise_i, ref_rise_i}),
        .edge_o (edges)
    );

    cdm_idx_ctr #(.W(IDX_W)) u_idx (
        .clk   (clk),
        .rst_n (rst_n),
        .idx_o (idx)
    );

    cdm_pair_fsm #(.IDX_W(IDX_W)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .ref_edge_i     (edges[LANE_RF]),
        .sig_edge_i     (edges[LANE_SG]),
        .idx_i          (idx),
        .dly_o          (delay_o),
        .dly_vld_o      (delay_vld_o),
        .miss_ref_req_o (miss_ref_req),
        .miss_sig_req_o (miss_sig_req)
    );

    cdm_sat_ctr #(.W(MISS_W)) u_miss_ref (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (miss_ref_req),
        .cnt_o   (miss_ref_cnt_o),
        .pulse_o (miss_ref_inc_o)
    );

    cdm_sat_ctr #(.W(MISS_W)) u_miss_sig (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc_i   (miss_sig_req),
        .cnt_o   (miss_sig_cnt_o),
        .pulse_o (miss_sig_inc_o)
    );

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({delay_vld_o, miss_ref_inc_o, miss_sig_inc_o}));

    // R5
    miss_ref_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_ref_inc_o |-> !delay_vld_o && $past(rst_n));

endmodule

// File: tb/cdm_delay_meter_tb.sv
// Bench for cdm_delay_meter. A behavioural model is stepped once per clock
// and compared with the outputs on every cycle, and directed checks are
// placed at the corner cases.
module cdm_delay_meter_tb;

    localparam int CLK_PERIOD = 10;
    localparam int IDX_W      = 32;
    localparam int MISS_W     = 4;
    localparam int MISS_MAX   = (1 << MISS_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_i = 1'b0, sig_i = 1'b0;
    logic ref_rise_i = 1'b1, sig_rise_i = 1'b1;
    logic [IDX_W-1:0]  delay_o;
    logic              delay_vld_o;
    logic [MISS_W-1:0] miss_ref_cnt_o, miss_sig_cnt_o;
    logic              miss_ref_inc_o, miss_sig_inc_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Model state
    int          m_state;
    bit          m_sig_seen;
    logic [31:0] m_now, m_ref;
    logic        m_prev_r, m_prev_s;
    logic [31:0] e_dly;
    bit          e_vld, e_mri, e_msi;
    int          e_mr, e_ms;

    always #(CLK_PERIOD/2) clk = ~clk;

    cdm_delay_meter #(.IDX_W(IDX_W), .MISS_W(MISS_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .ref_i(ref_i), .sig_i(sig_i),
        .ref_rise_i(ref_rise_i), .sig_rise_i(sig_rise_i),
        .delay_o(delay_o), .delay_vld_o(delay_vld_o),
        .miss_ref_cnt_o(miss_ref_cnt_o), .miss_ref_inc_o(miss_ref_inc_o),
        .miss_sig_cnt_o(miss_sig_cnt_o), .miss_sig_inc_o(miss_sig_inc_o)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", what, act, exp, $time);
        end
    endtask

    // Advance the model by one sample with the values the DUT sees at the edge.
    task automatic model(input logic rn, input logic r, input logic s);
        bit ce, se;
        if (!rn) begin
            m_state = 0; m_sig_seen = 0; m_now = 0; m_ref = 0;
            e_vld = 0; e_dly = 0; e_mri = 0; e_msi = 0; e_mr = 0; e_ms = 0;
        end else begin
            ce = ref_rise_i ? (r && !m_prev_r) : (!r && m_prev_r);
            se = sig_rise_i ? (s && !m_prev_s) : (!s && m_prev_s);
            e_vld = 0; e_mri = 0; e_msi = 0;
            if (m_state == 0) begin
                if (ce && se) begin
                    e_vld = 1; e_dly = 0; m_sig_seen = 1; m_ref = m_now;
                end else if (ce) begin
                    m_ref = m_now; m_state = 1;
                end else if (se && m_sig_seen && e_ms < MISS_MAX) begin
                    e_ms++; e_msi = 1;
                end
            end else begin
                if (se) begin
                    e_vld = 1; e_dly = m_now - m_ref; m_sig_seen = 1;
                    if (ce) m_ref = m_now;
                    else    m_state = 0;
                end else if (ce && e_mr < MISS_MAX) begin
                    e_mr++; e_mri = 1;
                end
            end
            m_now = m_now + 1;
        end
        m_prev_r = r;
        m_prev_s = s;
    endtask

    // One sample: compare the last edge's outputs, drive new inputs, advance the model.
    task automatic step(input logic rn, input logic r, input logic s);
        @(negedge clk);
        if (e_vld) chk(delay_o, e_dly, "R4 delay value");
        chk({31'd0, delay_vld_o}, {31'd0, e_vld}, "R4 delay valid");
        chk({28'd0, miss_ref_cnt_o}, e_mr, "R5 missed-reference count");
        chk({31'd0, miss_ref_inc_o}, {31'd0, e_mri}, "R9 missed-reference pulse");
        chk({28'd0, miss_sig_cnt_o}, e_ms, "R6 missed-signal count");
        chk({31'd0, miss_sig_inc_o}, {31'd0, e_msi}, "R9 missed-signal pulse");
        rst_n = rn; ref_i = r; sig_i = s;
        model(rn, r, s);
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired (R1 run never completed)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) step(1'b0, 1'b0, 1'b0);
        // R1 reset state
        chk(delay_o, 0, "R1 delay after reset");
        chk({31'd0, delay_vld_o}, 0, "R1 valid after reset");
        chk({28'd0, miss_ref_cnt_o}, 0, "R1 ref miss count after reset");
        chk({28'd0, miss_sig_cnt_o}, 0, "R1 sig miss count after reset");

        // R6: first signal edge after reset is not a miss
        step(1'b1, 1'b0, 1'b1);
        chk({28'd0, miss_sig_cnt_o}, 0, "R6 first signal edge exempt");
        chk({31'd0, miss_sig_inc_o}, 0, "R6 no pulse on first signal edge");
        step(1'b1, 1'b0, 1'b0);

        // R3 then R4: reference edge, three samples later a signal edge
        step(1'b1, 1'b1, 1'b0);
        chk({31'd0, delay_vld_o}, 0, "R3 no delay on arming edge");
        step(1'b1, 1'b1, 1'b0);
        step(1'b1, 1'b1, 1'b0);
        step(1'b1, 1'b1, 1'b1);
        chk({31'd0, delay_vld_o}, 1, "R4 valid on pairing");
        chk(delay_o, 3, "R4 delay of three samples");
        step(1'b1, 1'b0, 1'b0);
        chk({31'd0, delay_vld_o}, 0, "R10 valid lasts one cycle");

        // R6: now a lone signal edge counts
        step(1'b1, 1'b0, 1'b1);
        chk({28'd0, miss_sig_cnt_o}, 1, "R6 lone signal edge counted");
        chk({31'd0, miss_sig_inc_o}, 1, "R6 pulse on lone signal edge");
        step(1'b1, 1'b0, 1'b0);

        // R5: second reference edge is a miss, measurement not restarted
        step(1'b1, 1'b1, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b0);
        chk({28'd0, miss_ref_cnt_o}, 1, "R5 extra reference edge counted");
        step(1'b1, 1'b0, 1'b1);
        chk(delay_o, 3, "R5 delay measured from first reference edge");

        // R7: coincident edges while waiting for reference
        step(1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b1);
        chk({31'd0, delay_vld_o}, 1, "R7 valid on coincident pair");
        chk(delay_o, 0, "R7 zero delay");
        chk({28'd0, miss_sig_cnt_o}, 1, "R7 no signal miss");

        // R8: coincident edges while waiting for signal
        step(1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b1);
        chk(delay_o, 2, "R8 pair completes");
        chk({28'd0, miss_ref_cnt_o}, 1, "R8 no reference miss");
        step(1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b1);
        chk(delay_o, 2, "R8 new measurement from coincident reference");

        // R2: falling polarity; rising transitions ignored
        ref_rise_i = 1'b0; sig_rise_i = 1'b0;
        step(1'b1, 1'b1, 1'b1);
        chk({31'd0, delay_vld_o}, 0, "R2 rising ignored under falling polarity");
        step(1'b1, 1'b0, 1'b1);
        step(1'b1, 1'b0, 1'b1);
        step(1'b1, 1'b0, 1'b0);
        chk(delay_o, 2, "R2 falling edges measured");
        ref_rise_i = 1'b1; sig_rise_i = 1'b1;

        // R9: saturate both counters
        for (int i = 0; i < 20; i++) begin
            step(1'b1, 1'b0, 1'b1);
            step(1'b1, 1'b0, 1'b0);
        end
        chk({28'd0, miss_sig_cnt_o}, MISS_MAX, "R9 signal count saturates");
        step(1'b1, 1'b1, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 20; i++) begin
            step(1'b1, 1'b1, 1'b0);
            step(1'b1, 1'b0, 1'b0);
        end
        chk({28'd0, miss_ref_cnt_o}, MISS_MAX, "R9 reference count saturates");
        chk({31'd0, miss_ref_inc_o}, 0, "R9 no pulse at saturation");
        step(1'b1, 1'b0, 1'b1);

        // Random phase with polarity flips and mid-run resets (R1)
        for (int i = 0; i < 4000; i++) begin
            if (($urandom % 97) == 0) begin
                ref_rise_i = 1'($urandom);
                sig_rise_i = 1'($urandom);
            end
            step(($urandom % 500) != 0, 1'($urandom), 1'($urandom));
        end
        step(1'b1, 1'b0, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule